// File: doc/BRIEF.md
# Single-Precision Round-to-Integral Unit

This combinational unit takes one single-precision floating-point operand and rounds it to an integral value. The result stays in the same 32-bit floating-point format. A 3-bit rounding-mode field selects the rounding direction. That field can also defer to a dynamic mode supplied on a separate input. A select input chooses between two variants: the plain variant, which never reports precision loss, and the exact variant, which reports inexact whenever rounding changed the value.

Inside the unit, the operand is first sorted into a class: zero, infinity, quiet NaN, signaling NaN, magnitude below one, magnitude with fraction bits, or already integral. The effective rounding mode is resolved in parallel. The rounding itself works on the combined exponent and mantissa field as one unsigned integer. Because of this, a round-up that overflows the mantissa carries straight into the exponent. Flags and NaN handling are merged at the top.

Top module: `fpr_round_integral`

## Requirements
- R1: The effective mode is taken from `rm_i`. The codes are 000 ties-to-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity and 100 ties-away-from-zero. When `rm_i` is 111, the code on `dyn_rm_i` is used instead.
- R2: If the effective mode is 101, 110 or 111, the mode is illegal. The result is then 0x7FC00000 with `invalid_o`=1 and `inexact_o`=0, whatever the operand.
- R3: A zero or infinite operand (exponent field 0 with mantissa 0, or exponent field 255 with mantissa 0) is returned bit for bit, and no flag is raised.
- R4: An operand whose exponent field is at least 150 (unbiased exponent 23 or more) and below 255 is returned unchanged, and no flag is raised.
- R5: Any NaN operand returns 0x7FC00000. `invalid_o` is 1 only for a signaling NaN, which is a NaN with mantissa bit 22 clear. `inexact_o` stays 0.
- R6: A nonzero operand with magnitude below 1.0, subnormals included, returns ±0 or ±1.0. Under ties-to-even, a value of exactly 0.5 gives 0 and anything above 0.5 gives 1. Ties-away gives 1 from 0.5 upward. Toward minus infinity gives -1 for a negative operand. Toward plus infinity gives +1 for a positive operand.
- R7: The result sign always equals the operand sign for non-NaN operands, so a negative value that rounds to zero returns -0 (0x80000000).
- R8: For exponent fields 127 to 149, the fraction bits are rounded according to the mode. Ties go to the even integer under mode 000 and away from zero under mode 100. A round-up that overflows the mantissa yields the next power of two.
- R9: `inexact_o` is 1 only when `exact_i`=1, the mode is legal, the operand is not NaN, and the result differs from the operand. With `exact_i`=0 it is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 32 | Single-precision operand |
| rm_i | input | 3 | Rounding-mode field, 111 selects the dynamic mode |
| dyn_rm_i | input | 3 | Dynamic rounding mode |
| exact_i | input | 1 | 1 selects the exact variant that reports inexact |
| res_o | output | 32 | Rounded integral value in single-precision format |
| invalid_o | output | 1 | Invalid-operation flag |
| inexact_o | output | 1 | Inexact flag |

## Verification
The interesting overlap is between the carry of a round-up into the exponent field and the inexact report of the exact variant. Both come out of one evaluation when an operand such as 8388607.5 is rounded upward. The bench provokes this overlap with directed operands just below a power of two. It also uses random operands whose exponents are concentrated in the fractional range, run under every mode and both variants. A reference model built on real arithmetic judges each result, recomputing the integral value from scratch and re-encoding it into bits.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int FP_W    = 1 + EXP_W + MAN_W;
    localparam int MAG_W   = EXP_W + MAN_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int INT_EXP = BIAS + MAN_W;
    localparam int NF_W    = $clog2(MAN_W + 1);

    localparam logic [FP_W-1:0]  CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [MAG_W-1:0] ONE_MAG   = {EXP_W'(BIAS), {MAN_W{1'b0}}};
    localparam logic [2:0]       RM_FIELD_DYN = 3'd7;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] mant;
    } fp_t;

    typedef enum logic [2:0] {
        RND_NE = 3'd0,
        RND_TZ = 3'd1,
        RND_DN = 3'd2,
        RND_UP = 3'd3,
        RND_MM = 3'd4
    } rnd_e;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_INF,
        CL_QNAN,
        CL_SNAN,
        CL_TINY,
        CL_FRAC,
        CL_INTG
    } cls_e;

    typedef struct packed {
        fp_t             op;
        cls_e            cls;
        logic [NF_W-1:0] nfrac;
    } opinfo_t;

    function automatic logic mode_ok(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic [MAN_W-1:0] low_mask(input logic [NF_W-1:0] n);
        return (MAN_W'(1) << n) - MAN_W'(1);
    endfunction

endpackage

// File: rtl/fpr_classify.sv
module fpr_classify
    import fpr_pkg::*;
(
    input  fp_t     op_i,
    output opinfo_t info_o
);

    always_comb begin
        info_o.op    = op_i;
        info_o.cls   = CL_FRAC;
        info_o.nfrac = '0;
        if (op_i.expo == '1) begin
            if (op_i.mant == '0)
                info_o.cls = CL_INF;
            else if (op_i.mant[MAN_W-1])
                info_o.cls = CL_QNAN;
            else
                info_o.cls = CL_SNAN;
        end else if (op_i.expo == '0 && op_i.mant == '0) begin
            info_o.cls = CL_ZERO;
        end else if (op_i.expo < EXP_W'(BIAS)) begin
            info_o.cls = CL_TINY;
        end else if (op_i.expo >= EXP_W'(INT_EXP)) begin
            info_o.cls = CL_INTG;
        end else begin
            info_o.cls   = CL_FRAC;
            info_o.nfrac = NF_W'(EXP_W'(INT_EXP) - op_i.expo);
        end
    end

    // R8: the fraction-bit count handed to the rounder stays inside the mantissa
    always_comb begin
        if (info_o.cls == CL_FRAC)
            a_r8_frac_count: assert (info_o.nfrac >= NF_W'(1) && info_o.nfrac <= NF_W'(MAN_W))
                else $error("fraction count out of range");
    end

endmodule

// File: rtl/fpr_mode_resolve.sv
module fpr_mode_resolve
    import fpr_pkg::*;
(
    input  logic [2:0] rm_i,
    input  logic [2:0] dyn_rm_i,
    output rnd_e       mode_o,
    output logic       legal_o
);

    logic [2:0] eff;

    always_comb begin
        eff     = (rm_i == RM_FIELD_DYN) ? dyn_rm_i : rm_i;
        legal_o = mode_ok(eff);
        mode_o  = legal_o ? rnd_e'(eff) : RND_NE;
    end

    // R1: a dynamic request with a legal dynamic code follows that code
    always_comb begin
        if (rm_i == RM_FIELD_DYN && legal_o)
            a_r1_dyn_follow: assert (mode_o == rnd_e'(dyn_rm_i))
                else $error("dynamic mode not followed");
    end

endmodule

// File: rtl/fpr_round_core.sv
module fpr_round_core
    import fpr_pkg::*;
(
    input  opinfo_t info_i,
    input  rnd_e    mode_i,
    output fp_t     rnd_o,
    output logic    lost_o
);

    fp_t              op;
    logic [MAN_W-1:0] mask;
    logic [MAN_W-1:0] frac_bits;
    logic [MAN_W-1:0] half;
    logic [MAN_W:0]   sig;
    logic             keep_lsb;
    logic             any_frac;
    logic             above;
    logic             tie;
    logic             up;
    logic             tiny_up;
    logic [MAG_W-1:0] trunc_mag;
    logic [MAG_W-1:0] step;

    always_comb begin
        op        = info_i.op;
        mask      = low_mask(info_i.nfrac);
        frac_bits = op.mant & mask;
        half      = MAN_W'(1) << (info_i.nfrac - NF_W'(1));
        sig       = {1'b1, op.mant};
        keep_lsb  = sig[info_i.nfrac];
        any_frac  = frac_bits != '0;
        above     = frac_bits > half;
        tie       = frac_bits == half;
        trunc_mag = {op.expo, op.mant & ~mask};
        step      = {{EXP_W{1'b0}}, mask} + MAG_W'(1);

        case (mode_i)
            RND_NE:  up = above | (tie & keep_lsb);
            RND_DN:  up = op.sign & any_frac;
            RND_UP:  up = ~op.sign & any_frac;
            RND_MM:  up = above | tie;
            default: up = 1'b0;
        endcase

        case (mode_i)
            RND_NE:  tiny_up = (op.expo == EXP_W'(BIAS - 1)) && (op.mant != '0);
            RND_DN:  tiny_up = op.sign;
            RND_UP:  tiny_up = ~op.sign;
            RND_MM:  tiny_up = op.expo == EXP_W'(BIAS - 1);
            default: tiny_up = 1'b0;
        endcase

        case (info_i.cls)
            CL_FRAC: begin
                rnd_o  = fp_t'({op.sign, trunc_mag + (up ? step : '0)});
                lost_o = any_frac;
            end
            CL_TINY: begin
                rnd_o  = fp_t'({op.sign, tiny_up ? ONE_MAG : {MAG_W{1'b0}}});
                lost_o = 1'b1;
            end
            default: begin
                rnd_o  = op;
                lost_o = 1'b0;
            end
        endcase
    end

    always_comb begin
        // R7: the rounder never alters the sign
        a_r7_sign_kept: assert (rnd_o.sign == info_i.op.sign)
            else $error("sign changed by rounding");
        // R6: small magnitudes land on zero or one
        if (info_i.cls == CL_TINY)
            a_r6_tiny_target: assert (rnd_o.mant == '0 &&
                                      (rnd_o.expo == '0 || rnd_o.expo == EXP_W'(BIAS)))
                else $error("small magnitude not mapped to zero or one");
        // R4: integral operands pass with nothing lost
        if (info_i.cls == CL_INTG)
            a_r4_intg_pass: assert (rnd_o == info_i.op && !lost_o)
                else $error("integral operand modified");
    end

endmodule

// File: rtl/fpr_round_integral.sv
module fpr_round_integral
    import fpr_pkg::*;
(
    input  logic [31:0] op_i,
    input  logic [2:0]  rm_i,
    input  logic [2:0]  dyn_rm_i,
    input  logic        exact_i,
    output logic [31:0] res_o,
    output logic        invalid_o,
    output logic        inexact_o
);

    opinfo_t info;
    rnd_e    mode;
    logic    legal;
    fp_t     rnd;
    logic    lost;
    logic    is_nan;

    fpr_classify u_classify (
        .op_i   (fp_t'(op_i)),
        .info_o (info)
    );

    fpr_mode_resolve u_mode (
        .rm_i     (rm_i),
        .dyn_rm_i (dyn_rm_i),
        .mode_o   (mode),
        .legal_o  (legal)
    );

    fpr_round_core u_core (
        .info_i (info),
        .mode_i (mode),
        .rnd_o  (rnd),
        .lost_o (lost)
    );

    always_comb begin
        is_nan    = (info.cls == CL_QNAN) || (info.cls == CL_SNAN);
        res_o     = (!legal || is_nan) ? CANON_NAN : rnd;
        invalid_o = !legal || (info.cls == CL_SNAN);
        inexact_o = exact_i && legal && lost;
    end

    always_comb begin
        // R9: only the exact variant may report precision loss
        if (inexact_o)
            a_r9_exact_only: assert (exact_i && res_o != op_i)
                else $error("inexact without exact variant or without change");
        // R5: NaN operands give the canonical NaN
        if (op_i[30:23] == 8'hFF && op_i[22:0] != '0)
            a_r5_nan_canon: assert (res_o == CANON_NAN && !inexact_o)
                else $error("NaN not canonicalised");
        // R3: zero and infinity pass through under a legal mode
        if (legal && op_i[22:0] == '0 && (op_i[30:23] == '0 || op_i[30:23] == '1))
            a_r3_passthru: assert (res_o == op_i && !invalid_o && !inexact_o)
                else $error("zero or infinity modified");
        // R2: illegal modes report invalid
        if (!legal)
            a_r2_illegal: assert (invalid_o && res_o == CANON_NAN)
                else $error("illegal mode not reported");
    end

endmodule

// File: tb/test_fpr_round_integral.sv
module test_fpr_round_integral;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic [31:0] op  = '0;
    logic [2:0]  rm  = '0;
    logic [2:0]  dyn = '0;
    logic        ex  = 1'b0;
    logic [31:0] res;
    logic        inv;
    logic        inx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    fpr_round_integral i_fpr_round_integral (
        .op_i      (op),
        .rm_i      (rm),
        .dyn_rm_i  (dyn),
        .exact_i   (ex),
        .res_o     (res),
        .invalid_o (inv),
        .inexact_o (inx)
    );

    function automatic logic [30:0] enc_mag(input int n);
        int p = 0;
        logic [31:0] sh;
        if (n == 0) return '0;
        for (int i = 0; i < 25; i++)
            if (((n >> i) & 1) == 1) p = i;
        sh = 32'(n) << (23 - p);
        return {8'(127 + p), sh[22:0]};
    endfunction

    function automatic logic [33:0] ref_fn(input logic [31:0] a, input logic [2:0] r,
                                           input logic [2:0] d, input logic x);
        logic [2:0] eff;
        int  e;
        logic [22:0] m;
        logic s;
        real mag, fl, df;
        int  n;
        eff = (r == 3'd7) ? d : r;
        s = a[31];
        e = int'(a[30:23]);
        m = a[22:0];
        if (eff > 3'd4) return {32'h7FC0_0000, 1'b1, 1'b0};
        if (e == 255) begin
            if (m == '0) return {a, 2'b00};
            return {32'h7FC0_0000, !m[22], 1'b0};
        end
        if (e >= 150 || (e == 0 && m == '0)) return {a, 2'b00};
        if (e == 0) mag = real'(m) * (2.0 ** (-149));
        else        mag = (real'(m) + 8388608.0) * (2.0 ** (e - 150));
        fl = $floor(mag);
        df = mag - fl;
        n  = $rtoi(fl);
        case (eff)
            3'd0: if (df > 0.5 || (df == 0.5 && (n % 2) == 1)) n = n + 1;
            3'd2: if (s && df > 0.0) n = n + 1;
            3'd3: if (!s && df > 0.0) n = n + 1;
            3'd4: if (df >= 0.5) n = n + 1;
            default: ;
        endcase
        return {s, enc_mag(n), 1'b0, x && df != 0.0};
    endfunction

    task automatic run(input logic [31:0] a, input logic [2:0] r, input logic [2:0] d,
                       input logic x, input string tag);
        logic [33:0] expv;
        @(posedge clk);
        #1;
        op = a; rm = r; dyn = d; ex = x;
        @(negedge clk);
        expv = ref_fn(a, r, d, x);
        n_chk++;
        if ({res, inv, inx} !== expv) begin
            n_fail++;
            $display("FAIL %s op=%h rm=%0d dyn=%0d ex=%0b actual res=%h inv=%b inx=%b expected res=%h inv=%b inx=%b",
                     tag, a, r, d, x, res, inv, inx, expv[33:2], expv[1], expv[0]);
        end
    endtask

    task automatic expect_res(input logic [31:0] want, input string tag);
        n_chk++;
        if (res !== want) begin
            n_fail++;
            $display("FAIL %s actual res=%h expected res=%h", tag, res, want);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired, all requirements, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        logic [2:0]  r, d;
        void'($urandom(32'h5EED_0042));

        run(32'h0000_0000, 3'd0, 3'd0, 1'b1, "R3 plus zero");
        run(32'h8000_0000, 3'd3, 3'd0, 1'b1, "R3 minus zero");
        run(32'hFF80_0000, 3'd2, 3'd0, 1'b1, "R3 minus infinity");
        run(32'h7FC1_2345, 3'd0, 3'd0, 1'b1, "R5 quiet NaN");
        run(32'hFF80_0001, 3'd1, 3'd0, 1'b0, "R5 signaling NaN");
        run(32'h4B00_0000, 3'd3, 3'd0, 1'b1, "R4 two to 23");
        run(32'hCB7F_FFFF, 3'd2, 3'd0, 1'b1, "R4 large negative");
        run(32'h3FC0_0000, 3'd0, 3'd0, 1'b1, "R8 1.5 ties even");
        expect_res(32'h4000_0000, "R8 1.5 ties even gives 2.0");
        run(32'h4020_0000, 3'd0, 3'd0, 1'b1, "R8 2.5 ties even");
        expect_res(32'h4000_0000, "R8 2.5 ties even gives 2.0");
        run(32'h4020_0000, 3'd4, 3'd0, 1'b1, "R8 2.5 ties away");
        run(32'h4AFF_FFFF, 3'd3, 3'd0, 1'b1, "R8 carry into exponent");
        expect_res(32'h4B00_0000, "R8 carry gives two to 23");
        run(32'h3F00_0000, 3'd0, 3'd0, 1'b1, "R6 half ties even");
        run(32'h3F00_0000, 3'd4, 3'd0, 1'b1, "R6 half ties away");
        run(32'hBE99_999A, 3'd2, 3'd0, 1'b1, "R6 -0.3 toward minus");
        run(32'hBE99_999A, 3'd3, 3'd0, 1'b1, "R7 -0.3 toward plus");
        expect_res(32'h8000_0000, "R7 negative zero kept");
        run(32'h0000_0001, 3'd3, 3'd0, 1'b1, "R6 subnormal up");
        run(32'hC0B0_0000, 3'd7, 3'd1, 1'b1, "R1 dynamic toward zero");
        run(32'hC0B0_0000, 3'd7, 3'd2, 1'b1, "R1 dynamic toward minus");
        run(32'h3FC0_0000, 3'd5, 3'd0, 1'b1, "R2 field 101");
        run(32'h0000_0000, 3'd7, 3'd6, 1'b0, "R2 dynamic 110");
        run(32'h4B00_0000, 3'd7, 3'd7, 1'b0, "R2 dynamic 111");
        run(32'h3FC0_0000, 3'd1, 3'd0, 1'b0, "R9 plain variant silent");
        run(32'h4040_0000, 3'd0, 3'd0, 1'b1, "R9 exact on integral");

        for (int i = 0; i < 4000; i++) begin
            a = $urandom;
            if ($urandom % 4 != 0) a[30:23] = 8'(105 + ($urandom % 50));
            r = 3'($urandom % 8);
            d = 3'($urandom % 8);
            if ($urandom % 4 != 0 && r > 3'd4 && r != 3'd7) r = 3'($urandom % 5);
            run(a, r, d, 1'($urandom), "R8 R9 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule